// File: doc/BRIEF.md
# Three-Wire Control Register File

This block is the control port of a multi-channel audio converter. A host sends 16-bit words over three wires: a data clock, a data line and a latch line. Each word carries a 4-bit register address and a 9-bit payload. A latch pulse writes the payload into one of nine control registers.

The registers hold three things:
- one attenuation level for each of six output channels, grouped as three left/right pairs;
- a master attenuation register that sets all six channels at once;
- two mode registers that select mute, de-emphasis, converter disable, word length, output routing, data format, frame-clock polarity, shared attenuation, sample-rate group and zero-detect enable.

Attenuation writes are staged: a level takes effect only when the write carries its load bit. The serial port may run asynchronously to the audio clock. All committed state is therefore copied into the audio clock domain as one coherent snapshot before it reaches the outputs.

Top module: `ctl_regfile_top`

## Requirements
- R1: A frame is shifted in MSB first on rising data-clock edges while the latch line is low. The last 13 bits are address A3..A0 followed by data D8..D0, and any earlier bits are discarded. The first rising data-clock edge that sees the latch line high commits the frame.
- R2: After reset, all six effective levels read 8'hFF, the routing field reads 4'b1001, and every other mode field reads 0.
- R3: A write to a channel or master address with D8 = 0 leaves every effective level unchanged.
- R4: Addresses 0/1, 4/5 and 6/7 are the left/right channels of pairs 0, 1 and 2 (channel index 0..5 in that order). A write to one of these addresses with D8 = 1 sets that channel's effective level to D7..D0 and leaves the other channels unchanged.
- R5: A write to address 8 with D8 = 1 sets all six effective levels to D7..D0 in the same update.
- R6: Address 2 holds the following fields: routing = D8..D5, word length = D4..D3, disable = D2, de-emphasis = D1, soft mute = D0.
- R7: Address 3 holds the following fields: zero-detect enable = D8, sample-rate group = D7..D6, shared attenuation = D2, frame-clock polarity = D1, I2S select = D0. D5..D3 are ignored.
- R8: While shared attenuation is 1, the right output of each pair shows the effective level of that pair's left channel. When it returns to 0, the right channel's own level reappears.
- R9: Writes to addresses 9 to 15 change no output.
- R10: Outputs change only as a whole. The change arrives three audio-clock edges after the commit edge, so they still hold the old values one audio-clock cycle after the commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Audio clock; all outputs are registered on it |
| rst_n | input | 1 | Active-low reset, sampled synchronously by both clocks |
| ser_clk | input | 1 | Serial data clock |
| ser_dat | input | 1 | Serial data line |
| ser_lat | input | 1 | Latch line; high at a data-clock edge commits the frame |
| att_lvl | output | 48 | Effective attenuation, channel n at bits 8n+7..8n |
| route | output | 4 | Output routing code |
| wlen | output | 2 | Input word length code |
| dac_off | output | 1 | Converter disable |
| deemph | output | 1 | De-emphasis enable |
| soft_mute | output | 1 | Soft mute request |
| zdet_en | output | 1 | Zero-detect automute enable |
| rate_grp | output | 2 | Sample-rate group |
| att_share | output | 1 | Shared attenuation mode |
| lr_pol | output | 1 | Frame-clock polarity |
| i2s_fmt | output | 1 | I2S data format select |

## Verification
Every channel address is written with a distinct level, and the upper three frame bits are filled with junk. A swapped address decode or a misaligned shift would therefore land a value on the wrong channel or corrupt a field. Staged writes with the load bit clear are followed by loaded writes to the same address, which separates storing a level from applying it. Master writes are issued both with and without the load bit. Shared mode is toggled around a write to a right channel, which shows whether the mirror follows the left level while the right value is still kept. The mode registers are written with two opposite bit patterns plus ignored bits, and the output is sampled one cycle after a commit to confirm that nothing changes early.

// File: rtl/ctlrf_pkg.sv
// Package: shared constants, the register address map and the mode record
// used by the three-wire control register file.
package ctlrf_pkg;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 9;
    localparam int LVL_W   = 8;
    localparam int PAIRS   = 3;
    localparam int NCH     = 2 * PAIRS;
    localparam int PAYLD_W = ADDR_W + DATA_W;

    localparam logic [ADDR_W-1:0] A_MODE   = 4'd2;
    localparam logic [ADDR_W-1:0] A_FMT    = 4'd3;
    localparam logic [ADDR_W-1:0] A_MASTER = 4'd8;
    localparam logic [3:0]        ROUTE_RST = 4'b1001;

    // Mode record; routing is the most significant field
    typedef struct packed {
        logic [3:0] route;
        logic [1:0] wlen;
        logic       off;
        logic       deemph;
        logic       mute;
        logic       zdet;
        logic [1:0] rate;
        logic       share;
        logic       lrpol;
        logic       i2s;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);
    localparam logic [MODE_W-1:0] MODE_RST = {ROUTE_RST, {(MODE_W-4){1'b0}}};

    // Address of channel ch: pair 0 at 0/1, pair p>0 at 2p+2 / 2p+3
    function automatic logic [ADDR_W-1:0] chan_addr(input int ch);
        int pair;
        pair = ch / 2;
        if (pair == 0) return ADDR_W'(ch % 2);
        return ADDR_W'(2 * pair + 2 + ch % 2);
    endfunction
endpackage

// File: rtl/ser_shift.sv
// Serial shifter: on each rising data-clock edge with the latch line low,
// shifts one bit in (MSB first). Only the last PAYLD_W bits are kept, so the
// leading unused frame bits fall off the end. The first edge that sees the
// latch line high raises wr_en for that edge.
// Assumes: latch is raised only after the whole frame has been clocked in,
// and is seen by at least one rising data-clock edge.
module ser_shift #(
    parameter int PAYLD_W = ctlrf_pkg::PAYLD_W
) (
    input  logic               ser_clk,
    input  logic               rst_n,
    input  logic               ser_dat,
    input  logic               ser_lat,
    output logic [PAYLD_W-1:0] payload,
    output logic               wr_en
);
    logic lat_q;

    // shift data while the latch is low; remember the previous latch level
    always_ff @(posedge ser_clk) begin
        if (!rst_n) begin
            payload <= '0;
            lat_q   <= 1'b0;
        end else begin
            lat_q <= ser_lat;
            if (!ser_lat) payload <= {payload[PAYLD_W-2:0], ser_dat};
        end
    end

    assign wr_en = ser_lat && !lat_q;
endmodule

// File: rtl/ctl_bank.sv
// Register bank in the serial clock domain. It decodes the committed payload
// into channel levels (applied only with the load bit), a master write that
// applies to every channel, and the two mode registers. Every commit flips
// a toggle that announces a new snapshot to the audio domain.
// Assumes: bank contents stay stable long enough for the audio domain to
// sample them after each toggle.
module ctl_bank
    import ctlrf_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int LW = LVL_W,
    parameter int NC = NCH
) (
    input  logic            ser_clk,
    input  logic            rst_n,
    input  logic [AW+DW-1:0] payload,
    input  logic            wr_en,
    output mode_t           mode,
    output logic [NC*LW-1:0] eff_flat,
    output logic            tog
);
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic          ld;
    logic [LW-1:0] lvl;
    logic [LW-1:0] eff [NC];

    assign addr = payload[AW+DW-1:DW];
    assign data = payload[DW-1:0];
    assign ld   = data[DW-1];
    assign lvl  = data[LW-1:0];

    generate
        for (genvar ch = 0; ch < NC; ch++) begin : g_chan
            // apply a level on a loaded write to this channel or to the master
            always_ff @(posedge ser_clk) begin
                if (!rst_n)
                    eff[ch] <= '1;
                else if (wr_en && ld && (addr == chan_addr(ch) || addr == A_MASTER))
                    eff[ch] <= lvl;
            end
            assign eff_flat[ch*LW +: LW] = eff[ch];
        end
    endgenerate

    // mode registers: routing/length/disable/de-emphasis/mute and format word
    always_ff @(posedge ser_clk) begin
        if (!rst_n) begin
            mode <= mode_t'(MODE_RST);
        end else if (wr_en) begin
            if (addr == A_MODE)
                {mode.route, mode.wlen, mode.off, mode.deemph, mode.mute} <= data;
            else if (addr == A_FMT) begin
                mode.zdet  <= data[8];
                mode.rate  <= data[7:6];
                mode.share <= data[2];
                mode.lrpol <= data[1];
                mode.i2s   <= data[0];
            end
        end
    end

    // announce every commit to the audio domain
    always_ff @(posedge ser_clk) begin
        if (!rst_n) tog <= 1'b0;
        else if (wr_en) tog <= ~tog;
    end

    // R3: an unloaded level write changes no effective level
    p_noload_keeps_r3: assert property (@(posedge ser_clk) disable iff (!rst_n)
        (wr_en && !ld && addr != A_MODE && addr != A_FMT) |=> $stable(eff_flat));

    // R5: a loaded master write sets every channel to its level
    p_master_all_r5: assert property (@(posedge ser_clk) disable iff (!rst_n)
        (wr_en && ld && addr == A_MASTER) |=> (eff_flat == {NC{$past(lvl)}}));

    // R9: addresses above the master register are ignored
    p_undef_ignored_r9: assert property (@(posedge ser_clk) disable iff (!rst_n)
        (wr_en && addr > A_MASTER) |=> ($stable(eff_flat) && $stable(mode)));

    // R10: the snapshot announcement moves only on a commit
    p_tog_on_commit_r10: assert property (@(posedge ser_clk) disable iff (!rst_n)
        !wr_en |=> $stable(tog));
endmodule

// File: rtl/snap_xfer.sv
// Audio-domain mirror: synchronises the commit toggle through two flops and,
// when a change is seen, captures the whole bank snapshot in one cycle, so
// every field updates together.
// Assumes: the source holds its data stable for at least four audio clocks
// after each toggle.
module snap_xfer #(
    parameter int              W       = 8,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tog_in,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q
);
    logic s1, s2, s3;

    // synchronise the toggle and keep one delayed copy for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) {s1, s2, s3} <= 3'b000;
        else        {s1, s2, s3} <= {tog_in, s1, s2};
    end

    // capture the snapshot when the synchronised toggle changes
    always_ff @(posedge clk) begin
        if (!rst_n)        q <= RST_VAL;
        else if (s2 != s3) q <= d_in;
    end

    // R10: the mirror holds while no new commit has arrived
    p_hold_between_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (s2 == s3) |=> $stable(q));
endmodule

// File: rtl/ctl_regfile_top.sv
// Top: three-wire control port with staged attenuation, a master level and
// mode registers, mirrored into the audio clock domain. The right output of
// each pair follows the left level while shared attenuation is on.
// Assumes: the serial clock runs at most a quarter of the audio clock rate.
module ctl_regfile_top
    import ctlrf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ser_clk,
    input  logic                 ser_dat,
    input  logic                 ser_lat,
    output logic [NCH*LVL_W-1:0] att_lvl,
    output logic [3:0]           route,
    output logic [1:0]           wlen,
    output logic                 dac_off,
    output logic                 deemph,
    output logic                 soft_mute,
    output logic                 zdet_en,
    output logic [1:0]           rate_grp,
    output logic                 att_share,
    output logic                 lr_pol,
    output logic                 i2s_fmt
);
    localparam int EFF_W = NCH * LVL_W;
    localparam int SNP_W = MODE_W + EFF_W;
    localparam logic [SNP_W-1:0] SNP_RST = {MODE_RST, {EFF_W{1'b1}}};

    logic [PAYLD_W-1:0] payload;
    logic               wr_en;
    mode_t              mode_s, mode_q;
    logic [EFF_W-1:0]   eff_s, eff_q;
    logic               tog;
    logic [SNP_W-1:0]   snap_q;

    ser_shift #(.PAYLD_W(PAYLD_W)) u_shift (
        .ser_clk(ser_clk), .rst_n(rst_n), .ser_dat(ser_dat),
        .ser_lat(ser_lat), .payload(payload), .wr_en(wr_en));

    ctl_bank u_bank (
        .ser_clk(ser_clk), .rst_n(rst_n), .payload(payload), .wr_en(wr_en),
        .mode(mode_s), .eff_flat(eff_s), .tog(tog));

    snap_xfer #(.W(SNP_W), .RST_VAL(SNP_RST)) u_xfer (
        .clk(clk), .rst_n(rst_n), .tog_in(tog),
        .d_in({mode_s, eff_s}), .q(snap_q));

    assign mode_q = mode_t'(snap_q[SNP_W-1:EFF_W]);
    assign eff_q  = snap_q[EFF_W-1:0];

    generate
        for (genvar p = 0; p < PAIRS; p++) begin : g_pair
            // left passes through; right takes left while sharing is on
            assign att_lvl[(2*p)*LVL_W +: LVL_W]   = eff_q[(2*p)*LVL_W +: LVL_W];
            assign att_lvl[(2*p+1)*LVL_W +: LVL_W] = mode_q.share ?
                eff_q[(2*p)*LVL_W +: LVL_W] : eff_q[(2*p+1)*LVL_W +: LVL_W];

            // R8: shared mode shows the left level on both outputs of a pair
            p_share_mirror_r8: assert property (@(posedge clk) disable iff (!rst_n)
                att_share |-> (att_lvl[(2*p+1)*LVL_W +: LVL_W] ==
                               att_lvl[(2*p)*LVL_W +: LVL_W]));
        end
    endgenerate

    assign route     = mode_q.route;
    assign wlen      = mode_q.wlen;
    assign dac_off   = mode_q.off;
    assign deemph    = mode_q.deemph;
    assign soft_mute = mode_q.mute;
    assign zdet_en   = mode_q.zdet;
    assign rate_grp  = mode_q.rate;
    assign att_share = mode_q.share;
    assign lr_pol    = mode_q.lrpol;
    assign i2s_fmt   = mode_q.i2s;
endmodule

// File: tb/ctl_regfile_top_test.sv
// Directed bench for the three-wire control register file.
module ctl_regfile_top_test;
    localparam int HALF = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0, ser_dat = 1'b0, ser_lat = 1'b0;
    logic [47:0] att_lvl;
    logic [3:0]  route;
    logic [1:0]  wlen, rate_grp;
    logic        dac_off, deemph, soft_mute, zdet_en, att_share, lr_pol, i2s_fmt;

    int total = 0, bad = 0;
    bit done = 0;

    logic [7:0] m_eff [6];
    logic [14:0] m_mode;

    always #4 clk = ~clk;

    ctl_regfile_top uut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_lat(ser_lat), .att_lvl(att_lvl), .route(route), .wlen(wlen),
        .dac_off(dac_off), .deemph(deemph), .soft_mute(soft_mute),
        .zdet_en(zdet_en), .rate_grp(rate_grp), .att_share(att_share),
        .lr_pol(lr_pol), .i2s_fmt(i2s_fmt));

    function automatic logic [14:0] mode_now();
        return {route, wlen, dac_off, deemph, soft_mute, zdet_en, rate_grp,
                att_share, lr_pol, i2s_fmt};
    endfunction

    function automatic logic [47:0] att_exp();
        logic [47:0] v;
        for (int ch = 0; ch < 6; ch++)
            v[ch*8 +: 8] = (m_mode[2] && ch % 2 == 1) ? m_eff[ch-1] : m_eff[ch];
        return v;
    endfunction

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic check_all(input string req);
        check({req, " levels"}, {16'h0, att_lvl}, {16'h0, att_exp()});
        check({req, " modes"}, {49'h0, mode_now()}, {49'h0, m_mode});
    endtask

    task automatic sclk_pulse();
        repeat (HALF) @(negedge clk);
        ser_clk = 1'b1;
        repeat (HALF) @(negedge clk);
        ser_clk = 1'b0;
    endtask

    // send junk 3'b101, then address and data, then latch; optionally look early
    task automatic write_reg(input logic [3:0] a, input logic [8:0] d, input bit early);
        logic [15:0] fr;
        logic [47:0] old_att;
        logic [14:0] old_mode;
        fr = {3'b101, a, d};
        old_att = att_lvl;
        old_mode = mode_now();
        for (int i = 15; i >= 0; i--) begin
            ser_dat = fr[i];
            sclk_pulse();
        end
        ser_lat = 1'b1;
        repeat (HALF) @(negedge clk);
        ser_clk = 1'b1;
        @(negedge clk);
        if (early) begin
            check("R10 early levels", {16'h0, att_lvl}, {16'h0, old_att});
            check("R10 early modes", {49'h0, mode_now()}, {49'h0, old_mode});
        end
        repeat (HALF - 1) @(negedge clk);
        ser_clk = 1'b0;
        repeat (HALF) @(negedge clk);
        ser_lat = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset();
        for (int ch = 0; ch < 6; ch++) m_eff[ch] = 8'hFF;
        m_mode = {4'b1001, 11'b0};
        check_all("R2 reset");
    endtask

    task automatic t_load();
        logic [3:0] addrs [6] = '{4'd0, 4'd1, 4'd4, 4'd5, 4'd6, 4'd7};
        for (int ch = 0; ch < 6; ch++) begin
            write_reg(addrs[ch], {1'b1, 8'h10 + 8'(ch * 17)}, 1'b0);
            m_eff[ch] = 8'h10 + 8'(ch * 17);
            check_all("R4 R1 loaded channel write");
        end
    endtask

    task automatic t_stage();
        write_reg(4'd4, {1'b0, 8'hA5}, 1'b0);
        check_all("R3 staged write");
        write_reg(4'd8, {1'b0, 8'h99}, 1'b0);
        check_all("R3 staged master");
        write_reg(4'd4, {1'b1, 8'h5A}, 1'b0);
        m_eff[2] = 8'h5A;
        check_all("R4 load after stage");
    endtask

    task automatic t_mode2();
        write_reg(4'd2, 9'b0110_10_1_0_1, 1'b0);
        m_mode[14:6] = 9'b0110_10_1_0_1;
        check_all("R6 pattern a");
        write_reg(4'd2, 9'b0011_01_0_1_0, 1'b0);
        m_mode[14:6] = 9'b0011_01_0_1_0;
        check_all("R6 pattern b");
    endtask

    task automatic t_mode3();
        write_reg(4'd3, 9'b1_10_111_0_1_0, 1'b0);
        m_mode[5:0] = {1'b1, 2'b10, 1'b0, 1'b1, 1'b0};
        check_all("R7 format fields");
        write_reg(4'd3, 9'b0_01_000_0_0_1, 1'b0);
        m_mode[5:0] = {1'b0, 2'b01, 1'b0, 1'b0, 1'b1};
        check_all("R7 format fields b");
    endtask

    task automatic t_share();
        write_reg(4'd3, 9'b0_01_000_1_0_1, 1'b0);
        m_mode[2] = 1'b1;
        check_all("R8 shared on");
        write_reg(4'd1, {1'b1, 8'h77}, 1'b0);
        m_eff[1] = 8'h77;
        check_all("R8 right write while shared");
        write_reg(4'd3, 9'b0_01_000_0_0_1, 1'b0);
        m_mode[2] = 1'b0;
        check_all("R8 shared off");
    endtask

    task automatic t_master();
        write_reg(4'd8, {1'b1, 8'h3C}, 1'b0);
        for (int ch = 0; ch < 6; ch++) m_eff[ch] = 8'h3C;
        check_all("R5 master load");
        write_reg(4'd5, {1'b1, 8'h10}, 1'b0);
        m_eff[3] = 8'h10;
        check_all("R4 single after master");
    endtask

    task automatic t_undef();
        write_reg(4'd9, 9'h1FF, 1'b0);
        check_all("R9 address 9");
        write_reg(4'd12, 9'h000, 1'b0);
        check_all("R9 address 12");
        write_reg(4'd15, 9'h1FF, 1'b0);
        check_all("R9 address 15");
    endtask

    task automatic t_timing();
        write_reg(4'd0, {1'b1, 8'hE1}, 1'b1);
        m_eff[0] = 8'hE1;
        check_all("R10 late update");
        write_reg(4'd2, 9'b1001_11_0_0_1, 1'b1);
        m_mode[14:6] = 9'b1001_11_0_0_1;
        check_all("R10 late mode update");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        sclk_pulse();
        sclk_pulse();
        @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_load();
        t_stage();
        t_mode2();
        t_mode3();
        t_share();
        t_master();
        t_undef();
        t_timing();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule